// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block produces an active-low marker, `sync_n`, for two divided clocks that share one source clock. The divided clocks are called A and C here. Each clock is described only by its integer divide value. The block never generates the clocks. It tracks where they sit in the source-clock domain and pulls `sync_n` low for one period of the faster of the two clocks. The pulse ends on the next source edge where both divided clocks rise together. Logic downstream can use the rising edge of `sync_n` as a frame marker, even when neither clock is an integer multiple of the other.

The block assumes one alignment rule. Both divided clocks have a rising edge at phase zero, and that phase is fixed whenever the block restarts. The spacing between common edges is the least common multiple of the two divide values, counted in source cycles. When the two divide values are equal, every edge is common. In that case the marker is low for one output period and then high for one output period, so it runs at half the output rate. A reset or any change of either divide input restarts the phase count.

Top module: `coedge_sync_gen`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `sync_n` is 1 after that edge. The first edge that samples `rst` low is phase k=0 of a new alignment.
- R2: `div_a` and `div_c` are integer divide values. A value of 0 acts as 1, and any value above MAX_DIV (default 12) acts as MAX_DIV.
- R3: Clock A rises at every source edge k that is a multiple of its divide value Na. Clock C rises at every multiple of Nc. Common rising edges fall at multiples of L = lcm(Na, Nc).
- R4: Each low pulse lasts exactly F = min(Na, Nc) source cycles, which is one period of the faster clock.
- R5: `sync_n` goes high again exactly at the edges k that are multiples of the pulse period P. For unequal values P = L, and the phase counter is 0 at that edge.
- R6: Outside the pulse window `sync_n` is 1. After edge k, `sync_n` is 0 exactly when (k mod P) >= P - F.
- R7: When Na equals Nc, P = 2*Na. The marker is low for Na cycles and high for Na cycles.
- R8: An edge that samples a value of `div_a` or `div_c` different from the previous edge becomes k=0 of the new alignment. `sync_n` is 1 after that edge, even if a pulse was in progress.
- R9: The marker is produced for every pair of divide values, including pairs where neither value divides the other (for example 3:2 and 4:3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common source clock of both divided clocks |
| rst | input | 1 | Synchronous active-high reset |
| div_a | input | DIV_W | Divide value of clock A |
| div_c | input | DIV_W | Divide value of clock C |
| sync_n | output | 1 | Active-low coincident-edge marker, registered |

## Verification
The bench sweeps every ordered pair of divide values from 1 to 12. Equal pairs exercise the half-rate case. Pairs where one value divides the other show that the pulse follows the faster clock rather than the slower one. Coprime pairs and pairs with a shared factor show that the period is the least common multiple and not the product. Separate runs apply out-of-range and zero divide values to expose clamping, and apply a reset and a ratio change during a low pulse to show that the output returns high and the phase count restarts.

// File: rtl/coedge_sync_pkg.sv
package coedge_sync_pkg;

  // Default upper limit on either divide value.
  localparam int unsigned DEF_MAX_DIV = 12;

  // Bound on the marker period for a given divide limit:
  // the lcm of two values is at most m*m, and the equal case needs 2*m.
  function automatic int unsigned period_bound(input int unsigned m);
    return m * m + 2 * m;
  endfunction

endpackage

// File: rtl/coedge_ratio_calc.sv
// Combinational: clamp both divide values, find the faster one,
// and find the marker period from a grid of multiple comparisons.
module coedge_ratio_calc #(
  parameter int unsigned MAX_DIV = 12,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned CW      = 8
) (
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_c,
  output logic [CW-1:0]    fast,
  output logic [CW-1:0]    period
);

  logic [CW-1:0] na, nc;
  logic [CW-1:0] lcm;
  logic [CW-1:0] cand [MAX_DIV];
  logic [MAX_DIV-1:0] hit;

  always_comb begin
    if (div_a == '0)                    na = CW'(1);
    else if (32'(div_a) > 32'(MAX_DIV)) na = CW'(MAX_DIV);
    else                                na = CW'(div_a);
    if (div_c == '0)                    nc = CW'(1);
    else if (32'(div_c) > 32'(MAX_DIV)) nc = CW'(MAX_DIV);
    else                                nc = CW'(div_c);
  end

  // Row i: candidate na*(i+1); hit when some nc*(j+1) equals it.
  for (genvar i = 0; i < MAX_DIV; i++) begin : g_row
    localparam logic [CW-1:0] MUL_I = CW'(i + 1);
    logic [MAX_DIV-1:0] match;
    assign cand[i] = na * MUL_I;
    for (genvar j = 0; j < MAX_DIV; j++) begin : g_col
      localparam logic [CW-1:0] MUL_J = CW'(j + 1);
      assign match[j] = ((nc * MUL_J) == cand[i]);
    end
    assign hit[i] = |match;
  end

  // Lowest hitting multiple is the lcm (row nc-1 always hits).
  always_comb begin
    lcm = cand[MAX_DIV-1];
    for (int i = MAX_DIV - 1; i >= 0; i--) begin
      if (hit[i]) lcm = cand[i];
    end
  end

  assign fast   = (na < nc) ? na : nc;
  assign period = (na == nc) ? (lcm << 1) : lcm;

endmodule

// File: rtl/coedge_phase_ctr.sv
// Source-cycle phase counter modulo the marker period.
module coedge_phase_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] ph_next,
  output logic [CW-1:0] ph_q
);

  always_comb begin
    if (restart)                         ph_next = '0;
    else if (ph_q >= period - CW'(1))    ph_next = '0;
    else                                 ph_next = ph_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_next;
  end

endmodule

// File: rtl/coedge_pulse_shaper.sv
// Registered marker: low in the last 'fast' phases of each period.
module coedge_pulse_shaper #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] ph_next,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] fast,
  output logic          sync_n
);

  logic in_window;
  assign in_window = (ph_next >= (period - fast));

  always_ff @(posedge clk) begin
    if (rst || restart) sync_n <= 1'b1;
    else                sync_n <= ~in_window;
  end

endmodule

// File: rtl/coedge_sync_gen.sv
module coedge_sync_gen
  import coedge_sync_pkg::*;
#(
  parameter int unsigned MAX_DIV = DEF_MAX_DIV,
  parameter int unsigned DIV_W   = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_c,
  output logic             sync_n
);

  localparam int unsigned PER_MAX = period_bound(MAX_DIV);
  localparam int unsigned CW      = $clog2(PER_MAX + 1);

  logic [CW-1:0]    fast, period, ph_next, ph_q;
  logic [DIV_W-1:0] a_prev, c_prev;
  logic             started;
  logic             restart;

  // Alignment is restarted after reset and on any input change.
  always_ff @(posedge clk) begin
    a_prev  <= div_a;
    c_prev  <= div_c;
    started <= ~rst;
  end

  assign restart = ~started || (div_a != a_prev) || (div_c != c_prev);

  coedge_ratio_calc #(.MAX_DIV(MAX_DIV), .DIV_W(DIV_W), .CW(CW)) u_calc (
    .div_a  (div_a),
    .div_c  (div_c),
    .fast   (fast),
    .period (period)
  );

  coedge_phase_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .period  (period),
    .ph_next (ph_next),
    .ph_q    (ph_q)
  );

  coedge_pulse_shaper #(.CW(CW)) u_shape (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .ph_next (ph_next),
    .period  (period),
    .fast    (fast),
    .sync_n  (sync_n)
  );

endmodule

// File: rtl/coedge_sync_chk.sv
module coedge_sync_chk #(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned CW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_a,
  input logic [DIV_W-1:0] div_c,
  input logic             sync_n,
  input logic [CW-1:0]    ph,
  input logic [CW-1:0]    fast
);

  logic [CW-1:0]    fast_q;
  logic [CW-1:0]    low_run;
  logic [DIV_W-1:0] a_q, c_q;

  always_ff @(posedge clk) begin
    fast_q  <= fast;
    a_q     <= div_a;
    c_q     <= div_c;
    low_run <= (rst || sync_n) ? '0 : low_run + CW'(1);
  end

  assert_idle_in_reset_R1: assert property (@(posedge clk)
    rst |=> sync_n);

  assert_width_bound_R4: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (low_run < fast_q));

  assert_rise_on_common_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (ph == '0));

  assert_low_off_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> (ph != '0));

  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ((div_a != a_q) || (div_c != c_q)) |=> sync_n);

endmodule

bind coedge_sync_gen coedge_sync_chk #(.DIV_W(DIV_W), .CW(CW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .div_a  (div_a),
  .div_c  (div_c),
  .sync_n (sync_n),
  .ph     (ph_q),
  .fast   (fast)
);

// File: tb/coedge_sync_gen_test.sv
`timescale 1ns/1ps
module coedge_sync_gen_test;

  localparam int MAX_DIV = 12;
  localparam int DIV_W   = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_a = 4'd2;
  logic [DIV_W-1:0] div_c = 4'd3;
  logic             sync_n;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  coedge_sync_gen #(.MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .div_a(div_a), .div_c(div_c), .sync_n(sync_n)
  );

  task automatic check(input logic got, input logic exp, input string req, input string ctx);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: sync_n=%b expected %b", req, ctx, got, exp);
    end
  endtask

  function automatic int norm(input int v);
    if (v == 0) return 1;
    if (v > MAX_DIV) return MAX_DIV;
    return v;
  endfunction

  function automatic int gcd(input int x, input int y);
    int p = x, q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  // Drive a pair at a negedge; edge k=0 is the next posedge.
  task automatic run_pair(input int ra, input int rc, input int cycles, input string force_tag);
    int na = norm(ra);
    int nc = norm(rc);
    int f  = (na < nc) ? na : nc;
    int l  = na / gcd(na, nc) * nc;
    int p  = (na == nc) ? 2 * l : l;
    bit coprime_like = (na % nc != 0) && (nc % na != 0);
    div_a = DIV_W'(ra);
    div_c = DIV_W'(rc);
    for (int k = 0; k < cycles; k++) begin
      logic  exp;
      string tag;
      @(posedge clk);
      @(negedge clk);
      exp = !((k % p) >= (p - f));
      if (force_tag != "")      tag = force_tag;
      else if (k == 0)          tag = "R8";
      else if (na == nc)        tag = "R7";
      else if (k % p == 0)      tag = "R5";
      else if (!exp)            tag = "R4";
      else if (coprime_like)    tag = "R9";
      else if (k % na == 0)     tag = "R3";
      else                      tag = "R6";
      check(sync_n, exp, tag, $sformatf("a=%0d c=%0d k=%0d", ra, rc, k));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: held in reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(sync_n, 1'b1, "R1", "during reset");
    end
    rst = 1'b0;
    // R1: first edge after release is k=0 (inputs unchanged)
    run_pair(2, 3, 14, "R1");

    // Full sweep of pairs: R3..R9
    for (int a = 1; a <= MAX_DIV; a++) begin
      for (int c = 1; c <= MAX_DIV; c++) begin
        int na = a, nc = c;
        int l  = na / gcd(na, nc) * nc;
        int p  = (na == nc) ? 2 * l : l;
        run_pair(a, c, 2 * p + 2, "");
      end
    end

    // R2: zero acts as 1, above limit acts as MAX_DIV
    run_pair(0, 5, 12, "R2");
    run_pair(15, 4, 26, "R2");
    run_pair(13, 0, 26, "R2");

    // R1: reset in the middle of a low pulse (4:6, P=12, low 8..11)
    run_pair(4, 6, 10, "");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(sync_n, 1'b1, "R1", "reset mid-pulse");
    rst = 1'b0;
    run_pair(4, 6, 30, "R1");

    // R8: ratio change during a low pulse (3:8, P=24, low 21..23)
    run_pair(3, 8, 23, "");
    check(sync_n, 1'b0, "R4", "inside pulse before change");
    run_pair(5, 2, 25, "");

    finish_run();
  end

endmodule